// File: doc/BRIEF.md
# Fixed-Ratio Synthesizer Divider Chain with Frequency-Error Monitor

This block is the digital core of a single-channel integer-N frequency synthesizer. A programmable divider turns the reference clock into a comparison-rate tick. A chain of fixed dividers clocked by the VCO produces an RF LO tick at half the VCO rate, a feedback tick at one RF LO period in 8064, and an IF LO tick at one RF LO period in 48. For a locked loop this places the IF LO at 168 times the comparison rate. A sample clock goes out to the baseband. It is either the reference clock itself or the RF LO divided by 96.

Every divided output is a one-cycle enable pulse on its source clock, so no clock is derived inside the block. The sample clock is the one exception, because it must leave the chip as a clock. A frequency-error monitor counts feedback ticks over a window of comparison periods. It then reports whether the VCO runs too fast or too slow, which lets software steer coarse tuning in the right direction. The two error flags reach the register clock through two-flop synchronizers.

The monitor is a three-state machine:
- MON_ALIGN is the state after reset. It moves to MON_COUNT on the first comparison tick.
- MON_COUNT counts feedback ticks and comparison ticks. It moves to MON_JUDGE on the comparison tick that completes the window.
- MON_JUDGE updates both flags, opens the next window, and returns to MON_COUNT unconditionally.

Top module: `synth_divider_chain`

## Requirements
- R1: With `ref_ratio` between 2 and 255, `comp_tick` is high for one `ref_clk` cycle in every `ref_ratio` cycles.
- R2: A `ref_ratio` of 0 or 1 divides by one: `comp_tick` is high on every `ref_clk` cycle.
- R3: A new `ref_ratio` is taken only at a terminal count. The period in progress finishes with the old ratio, and the following periods use the new one.
- R4: `rflo_tick` is high on every second `vco_clk` cycle.
- R5: `fb_tick` is high once every 16128 `vco_clk` cycles (8064 RF LO periods) and only in a cycle where `rflo_tick` and `iflo_tick` are also high.
- R6: `iflo_tick` is high once every 96 `vco_clk` cycles (48 RF LO periods) and only together with `rflo_tick`.
- R7: When `samp_sel` is 1, `samp_clk` follows `ref_clk`. When `samp_sel` is 0, `samp_clk` is a square wave with a period of 192 `vco_clk` cycles.
- R8: At the end of each window of WIN_PERIODS comparison periods, `vco_fast` is set if more than WIN_PERIODS+TOLERANCE feedback ticks were counted. `vco_slow` is set if fewer than WIN_PERIODS-TOLERANCE were counted. Neither is set when the count is within the tolerance band.
- R9: Both flags are 0 after reset and are never set together. They change only when a window is judged, and they reach the `reg_clk` outputs through two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| vco_clk | input | 1 | VCO clock (twice the RF LO) |
| reg_clk | input | 1 | Register-interface clock for the flags |
| rst_n | input | 1 | Asynchronous active-low reset, all domains |
| ref_ratio | input | 8 | Reference divide ratio; 0 and 1 divide by one |
| samp_sel | input | 1 | 1 selects the reference as sample clock, 0 selects RF LO/96 |
| comp_tick | output | 1 | Comparison-rate enable on `ref_clk` |
| rflo_tick | output | 1 | RF LO enable on `vco_clk` |
| iflo_tick | output | 1 | IF LO enable on `vco_clk` |
| fb_tick | output | 1 | Feedback-divider enable on `vco_clk` |
| samp_clk | output | 1 | Sample clock to the baseband |
| vco_fast | output | 1 | Feedback count above the band, on `reg_clk` |
| vco_slow | output | 1 | Feedback count below the band, on `reg_clk` |

## Verification
The assertions check the alignment of the VCO chain on every cycle: an IF LO tick always falls on an RF LO tick, and a feedback tick always falls on an IF LO tick. They also check that no divided tick repeats on consecutive cycles, that the active reference ratio changes only at a terminal count, and that the two flags stay exclusive and change only in MON_JUDGE. Only the bench scenarios can show the exact periods (R, 96 and 16128), when a ratio change takes effect, the sample-clock rates, and whether the flags report fast, slow or in-band for a given VCO frequency.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    typedef enum logic [1:0] {
        MON_ALIGN = 2'd0,
        MON_COUNT = 2'd1,
        MON_JUDGE = 2'd2
    } mon_state_t;

endpackage

// File: rtl/tick_div.sv
module tick_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_pass
            assign tick = en;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (en) begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
            end

            assign tick = en && (cnt_q == LAST);

            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R4
        end
    endgenerate

endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ratio,
    output logic          tick
);

    logic [RW-1:0] cur_q;
    logic [RW-1:0] cnt_q;
    logic [RW-1:0] eff;

    assign eff  = (ratio <= RW'(1)) ? RW'(1) : ratio;
    assign tick = (cnt_q == cur_q - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= RW'(1);
            cnt_q <= '0;
        end else if (tick) begin
            cur_q <= eff;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cur_q)); // R3

endmodule

// File: rtl/sync2.sv
module sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;

endmodule

// File: rtl/lock_monitor.sv
module lock_monitor
    import synth_div_pkg::*;
#(
    parameter int WIN_PERIODS = 32,
    parameter int TOLERANCE   = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic comp_tick,
    input  logic fb_toggle,
    output logic fast_flag,
    output logic slow_flag
);

    localparam int WW = $clog2(WIN_PERIODS + 1);
    localparam int FW = $clog2(4 * WIN_PERIODS + 2);
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_PERIODS - 1);
    localparam logic [FW-1:0] FB_MAX   = '1;

    mon_state_t    state_q, state_d;
    logic [WW-1:0] win_q;
    logic [FW-1:0] fbc_q;
    logic          hi_q, lo_q;
    logic          tgl_s, tgl_d_q, fb_edge;

    sync2 #(.W(1)) u_fb_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (fb_toggle),
        .q     (tgl_s)
    );

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) tgl_d_q <= 1'b0;
        else        tgl_d_q <= tgl_s;
    end

    assign fb_edge = tgl_s ^ tgl_d_q;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state_q <= MON_ALIGN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_ALIGN: if (comp_tick) state_d = MON_COUNT;
            MON_COUNT: if (comp_tick && win_q == WIN_LAST) state_d = MON_JUDGE;
            MON_JUDGE: state_d = MON_COUNT;
            default:   state_d = MON_ALIGN;
        endcase
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
            fbc_q <= '0;
            hi_q  <= 1'b0;
            lo_q  <= 1'b0;
        end else begin
            unique case (state_q)
                MON_ALIGN: begin
                    win_q <= '0;
                    fbc_q <= '0;
                end
                MON_COUNT: begin
                    if (comp_tick) win_q <= win_q + 1'b1;
                    if (fb_edge && fbc_q != FB_MAX) fbc_q <= fbc_q + 1'b1;
                end
                MON_JUDGE: begin
                    hi_q  <= int'(fbc_q) > WIN_PERIODS + TOLERANCE;
                    lo_q  <= int'(fbc_q) + TOLERANCE < WIN_PERIODS;
                    win_q <= comp_tick ? WW'(1) : '0;
                    fbc_q <= fb_edge ? FW'(1) : '0;
                end
                default: begin
                    win_q <= '0;
                    fbc_q <= '0;
                end
            endcase
        end
    end

    assign fast_flag = hi_q;
    assign slow_flag = lo_q;

    AST_FLAG_HOLD: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q != MON_JUDGE) |=> $stable({hi_q, lo_q})); // R9
    AST_FLAG_EXCL: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(hi_q && lo_q)); // R9

endmodule

// File: rtl/synth_divider_chain.sv
module synth_divider_chain #(
    parameter int RW          = 8,
    parameter int RF_DIV      = 2,
    parameter int FB_RATIO    = 8064,
    parameter int IF_RATIO    = 48,
    parameter int WIN_PERIODS = 32,
    parameter int TOLERANCE   = 2
) (
    input  logic          ref_clk,
    input  logic          vco_clk,
    input  logic          reg_clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ref_ratio,
    input  logic          samp_sel,
    output logic          comp_tick,
    output logic          rflo_tick,
    output logic          iflo_tick,
    output logic          fb_tick,
    output logic          samp_clk,
    output logic          vco_fast,
    output logic          vco_slow
);

    logic samp_tgl_q;
    logic fb_tgl_q;
    logic fast_ref, slow_ref;

    ref_divider #(.RW(RW)) u_ref_div (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .ratio (ref_ratio),
        .tick  (comp_tick)
    );

    tick_div #(.DIV(RF_DIV)) u_rf_div (
        .clk   (vco_clk),
        .rst_n (rst_n),
        .en    (1'b1),
        .tick  (rflo_tick)
    );

    tick_div #(.DIV(FB_RATIO)) u_fb_div (
        .clk   (vco_clk),
        .rst_n (rst_n),
        .en    (rflo_tick),
        .tick  (fb_tick)
    );

    tick_div #(.DIV(IF_RATIO)) u_if_div (
        .clk   (vco_clk),
        .rst_n (rst_n),
        .en    (rflo_tick),
        .tick  (iflo_tick)
    );

    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_tgl_q <= 1'b0;
            fb_tgl_q   <= 1'b0;
        end else begin
            if (iflo_tick) samp_tgl_q <= ~samp_tgl_q;
            if (fb_tick)   fb_tgl_q   <= ~fb_tgl_q;
        end
    end

    assign samp_clk = samp_sel ? ref_clk : samp_tgl_q;

    lock_monitor #(
        .WIN_PERIODS (WIN_PERIODS),
        .TOLERANCE   (TOLERANCE)
    ) u_mon (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .comp_tick (comp_tick),
        .fb_toggle (fb_tgl_q),
        .fast_flag (fast_ref),
        .slow_flag (slow_ref)
    );

    sync2 #(.W(2)) u_flag_sync (
        .clk   (reg_clk),
        .rst_n (rst_n),
        .d     ({fast_ref, slow_ref}),
        .q     ({vco_fast, vco_slow})
    );

    AST_FB_ON_IF: assert property (@(posedge vco_clk) disable iff (!rst_n)
        fb_tick |-> iflo_tick); // R5
    AST_IF_ON_RF: assert property (@(posedge vco_clk) disable iff (!rst_n)
        iflo_tick |-> rflo_tick); // R6

endmodule

// File: tb/tb_synth_divider_chain.sv
`timescale 1ns/1ps
module tb_synth_divider_chain;

    logic       ref_clk = 1'b0;
    logic       vco_clk = 1'b0;
    logic       reg_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [7:0] ref_ratio = 8'd5;
    logic       samp_sel  = 1'b0;
    logic       comp_tick, rflo_tick, iflo_tick, fb_tick, samp_clk;
    logic       vco_fast, vco_slow;

    realtime    vco_half = 0.25;
    int         n_checks = 0;
    int         n_fail   = 0;
    int         samp_edges = 0;

    always #4    reg_clk = ~reg_clk;
    always #31.5 ref_clk = ~ref_clk;
    always #(vco_half) vco_clk = ~vco_clk;

    synth_divider_chain #(
        .WIN_PERIODS (8),
        .TOLERANCE   (1)
    ) dut (
        .ref_clk   (ref_clk),
        .vco_clk   (vco_clk),
        .reg_clk   (reg_clk),
        .rst_n     (rst_n),
        .ref_ratio (ref_ratio),
        .samp_sel  (samp_sel),
        .comp_tick (comp_tick),
        .rflo_tick (rflo_tick),
        .iflo_tick (iflo_tick),
        .fb_tick   (fb_tick),
        .samp_clk  (samp_clk),
        .vco_fast  (vco_fast),
        .vco_slow  (vco_slow)
    );

    always @(posedge samp_clk) samp_edges++;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic ref_wait_tick();
        do @(negedge ref_clk); while (!comp_tick);
    endtask

    task automatic ref_interval(output int n);
        n = 0;
        do begin
            @(negedge ref_clk);
            n++;
        end while (!comp_tick);
    endtask

    task automatic vco_interval(input int sel, output int n);
        logic hit;
        n = 0;
        do begin
            @(negedge vco_clk);
            n++;
            hit = (sel == 0) ? rflo_tick : (sel == 1) ? iflo_tick : fb_tick;
        end while (!hit);
    endtask

    task automatic vco_wait(input int sel);
        int dummy;
        vco_interval(sel, dummy);
    endtask

    task automatic t_reset();
        @(negedge reg_clk);
        chk("R9 fast flag after reset", int'(vco_fast), 0);
        chk("R9 slow flag after reset", int'(vco_slow), 0);
    endtask

    task automatic t_ratio(input logic [7:0] r, input int exp);
        int n;
        @(negedge ref_clk);
        ref_ratio = r;
        ref_wait_tick();
        ref_wait_tick();
        ref_interval(n);
        chk($sformatf("R1/R2 period for ratio %0d", r), n, exp);
        ref_interval(n);
        chk($sformatf("R1/R2 repeat period for ratio %0d", r), n, exp);
    endtask

    task automatic t_ratio_change();
        int n;
        @(negedge ref_clk);
        ref_ratio = 8'd10;
        ref_wait_tick();
        ref_wait_tick();
        n = 0;
        repeat (3) begin
            @(negedge ref_clk);
            n++;
        end
        ref_ratio = 8'd4;
        do begin
            @(negedge ref_clk);
            n++;
        end while (!comp_tick);
        chk("R3 period in flight keeps old ratio", n, 10);
        ref_interval(n);
        chk("R3 next period uses new ratio", n, 4);
    endtask

    task automatic t_vco_chain();
        int n;
        vco_wait(0);
        vco_interval(0, n);
        chk("R4 RF LO tick spacing", n, 2);
        vco_wait(1);
        vco_interval(1, n);
        chk("R6 IF LO tick spacing", n, 96);
        vco_wait(2);
        vco_interval(2, n);
        chk("R5 feedback tick spacing", n, 16128);
    endtask

    task automatic t_sample_clock();
        int e0;
        samp_sel = 1'b0;
        #500;
        e0 = samp_edges;
        #9600;
        chk_rng("R7 sample clock from RF LO/96", samp_edges - e0, 99, 101);
        samp_sel = 1'b1;
        #500;
        e0 = samp_edges;
        #9600;
        chk_rng("R7 sample clock from reference", samp_edges - e0, 151, 154);
    endtask

    task automatic t_lock(input realtime half, input int exp_fast, input int exp_slow,
                          input string tag);
        vco_half = half;
        repeat (25000) @(posedge reg_clk);
        @(negedge reg_clk);
        chk({"R8 fast flag, ", tag}, int'(vco_fast), exp_fast);
        chk({"R8 slow flag, ", tag}, int'(vco_slow), exp_slow);
    endtask

    initial begin
        repeat (20) @(negedge reg_clk);
        rst_n = 1'b1;
        t_reset();
        t_ratio(8'd5, 5);
        t_ratio(8'd0, 1);
        t_ratio(8'd1, 1);
        t_ratio(8'd200, 200);
        t_ratio_change();
        t_vco_chain();
        t_sample_clock();
        ref_ratio = 8'd128;
        t_lock(0.25, 0, 0, "in band");
        t_lock(0.175, 1, 0, "VCO fast");
        t_lock(0.35, 0, 1, "VCO slow");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule